// File: doc/BRIEF.md
# Handshake-Triggered Spike Pulse Generator

This block turns handshake events on a spiking-array bus into fixed-width drive pulses. It watches three request lines: a spike request, an acknowledge, and a request to reset a neuron. When the spike request and the acknowledge become true together, the block emits one pre-synaptic pulse to drive a selected synapse row. When the neuron-reset request and the acknowledge become true together, it emits one post-synaptic pulse that clears a firing neuron cell. A single instance serves every processing element in a cluster, so only one pulse can be in flight at a time.

Each pulse is a set flip-flop followed by a delayed self-clear. The delay is a down-counter loaded from a programmable width register, and the unit of delay is the clock cycle. A wider pulse carries more energy into the cell, so fewer pulses are needed before a neuron fires. Software-side code therefore tunes the effective firing threshold through the width register alone. A one-cycle completion strobe follows every pulse.

Top module: `spk_pulse_gen`

## Requirements
- R1: After reset both pulse outputs and the done strobe are low. The width register holds its reset value of 4, so the first pulse after reset lasts 4 cycles.
- R2: When req_i and ack_i both become high in a cycle where no pulse is active, pre_pulse_o rises on the next clock edge. It stays high for exactly W cycles, where W is the effective width. If either line alone is high, no pulse starts.
- R3: When rst_req_i and ack_i both become high in a cycle where no pulse is active, post_pulse_o rises on the next clock edge and stays high for exactly W cycles.
- R4: A width register value of 0 behaves as 1, so each pulse lasts one cycle.
- R5: A write with width_we_i high loads width_i at the clock edge. Pulses that start afterwards use the new value. A write made while a pulse is active does not change the length of that pulse.
- R6: A trigger condition that becomes true while a pulse output is high is ignored. A condition that stays high after its pulse does not start a new pulse; it must fall and rise again.
- R7: If both trigger conditions become true in the same cycle, only the post-synaptic pulse is emitted.
- R8: done_o is high for exactly one cycle: the first cycle after a pulse output falls.
- R9: pre_pulse_o and post_pulse_o are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Spike request |
| ack_i | input | 1 | Acknowledge; required by both triggers |
| rst_req_i | input | 1 | Neuron-reset request |
| width_we_i | input | 1 | Width register write enable |
| width_i | input | 8 | Width value in cycles |
| pre_pulse_o | output | 1 | Pre-synaptic drive pulse |
| post_pulse_o | output | 1 | Post-synaptic reset pulse |
| done_o | output | 1 | One-cycle strobe after a pulse ends |

## Verification
The assertions treat the three request lines as synchronous levels that are held low while reset is active. They also treat the previous sampled value of each trigger condition as false immediately after reset. The bench drives every input on the falling clock edge and keeps all lines low throughout reset. It steps through widths 0 to 12 and also 255, for both pulse kinds. Around that sweep it adds targeted sequences: acknowledge arriving last, width writes during a pulse, retriggers during a pulse, held levels after a pulse, and simultaneous triggers.

// File: rtl/spk_pulse_pkg.sv
package spk_pulse_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_PRE  = 2'd1,
    KIND_POST = 2'd2
  } pulse_kind_e;

  localparam int COND_PRE  = 0;
  localparam int COND_POST = 1;
  localparam int N_COND    = 2;
endpackage

// File: rtl/spk_trig_detect.sv
module spk_trig_detect
  import spk_pulse_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        ack_i,
  input  logic        rst_req_i,
  output pulse_kind_e kind_o
);
  logic [N_COND-1:0] cond, cond_q, rise;

  assign cond[COND_PRE]  = req_i & ack_i;
  assign cond[COND_POST] = rst_req_i & ack_i;

  for (genvar g = 0; g < N_COND; g++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cond_q[g] <= 1'b0;
      else         cond_q[g] <= cond[g];
    end
    assign rise[g] = cond[g] & ~cond_q[g];
  end

  // reset pulse wins on a tie
  always_comb begin
    if (rise[COND_POST])     kind_o = KIND_POST;
    else if (rise[COND_PRE]) kind_o = KIND_PRE;
    else                     kind_o = KIND_NONE;
  end
endmodule

// File: rtl/spk_width_reg.sv
module spk_width_reg #(
  parameter int WIDTH_W   = 8,
  parameter int WIDTH_RST = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [WIDTH_W-1:0] d_i,
  output logic [WIDTH_W-1:0] width_eff_o
);
  localparam logic [WIDTH_W-1:0] RST_VAL = WIDTH_W'(WIDTH_RST);
  localparam logic [WIDTH_W-1:0] MIN_VAL = WIDTH_W'(1);

  logic [WIDTH_W-1:0] width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   width_q <= RST_VAL;
    else if (we_i) width_q <= d_i;
  end

  assign width_eff_o = (width_q == '0) ? MIN_VAL : width_q;
endmodule

// File: rtl/spk_pulse_timer.sv
module spk_pulse_timer
  import spk_pulse_pkg::*;
#(
  parameter int WIDTH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  pulse_kind_e        start_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               active_o,
  output pulse_kind_e        kind_o,
  output logic               done_o
);
  localparam logic [WIDTH_W-1:0] ONE = WIDTH_W'(1);

  logic               active_q, done_q;
  pulse_kind_e        kind_q;
  logic [WIDTH_W-1:0] cnt_q;

  // set on start, self-clear when the delay count runs out
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      kind_q   <= KIND_NONE;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (active_q) begin
        if (cnt_q == '0) begin
          active_q <= 1'b0;
          kind_q   <= KIND_NONE;
          done_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end else if (start_i != KIND_NONE) begin
        active_q <= 1'b1;
        kind_q   <= start_i;
        cnt_q    <= width_i - ONE;
      end
    end
  end

  assign active_o = active_q;
  assign kind_o   = kind_q;
  assign done_o   = done_q;

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && start_i != KIND_NONE) |=> (active_q && kind_q == $past(start_i)));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q != '0) |=> (active_q && $stable(kind_q)));

  assert_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!active_q && $past(active_q)));
endmodule

// File: rtl/spk_pulse_gen.sv
module spk_pulse_gen
  import spk_pulse_pkg::*;
#(
  parameter int WIDTH_W   = 8,
  parameter int WIDTH_RST = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               ack_i,
  input  logic               rst_req_i,
  input  logic               width_we_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               pre_pulse_o,
  output logic               post_pulse_o,
  output logic               done_o
);
  pulse_kind_e        start_kind, cur_kind;
  logic [WIDTH_W-1:0] width_eff;
  logic               active;

  spk_trig_detect u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ack_i     (ack_i),
    .rst_req_i (rst_req_i),
    .kind_o    (start_kind)
  );

  spk_width_reg #(.WIDTH_W(WIDTH_W), .WIDTH_RST(WIDTH_RST)) u_width (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (width_we_i),
    .d_i         (width_i),
    .width_eff_o (width_eff)
  );

  spk_pulse_timer #(.WIDTH_W(WIDTH_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_kind),
    .width_i  (width_eff),
    .active_o (active),
    .kind_o   (cur_kind),
    .done_o   (done_o)
  );

  assign pre_pulse_o  = active && (cur_kind == KIND_PRE);
  assign post_pulse_o = active && (cur_kind == KIND_POST);

  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pre_pulse_o && post_pulse_o));

  assert_prio_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pre_pulse_o && !post_pulse_o && $rose(req_i && ack_i) && $rose(rst_req_i && ack_i))
      |=> (post_pulse_o && !pre_pulse_o));

  assert_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_eff != '0));
endmodule

// File: tb/spk_pulse_gen_test.sv
module spk_pulse_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, ack = 1'b0, rrq = 1'b0, we = 1'b0;
  logic [7:0] wd = '0;
  logic       pre, post, done;
  int         n_cmp = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  spk_pulse_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_i(ack), .rst_req_i(rrq),
    .width_we_i(we), .width_i(wd),
    .pre_pulse_o(pre), .post_pulse_o(post), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_width(input int v);
    we = 1'b1; wd = 8'(v);
    @(negedge clk);
    we = 1'b0;
  endtask

  // inputs already set at the current negedge
  task automatic measure(input bit want_post, input int exp_w, input string tag);
    int len = 0, extra = 0, other = 0, derr = 0;
    for (int k = 1; k <= exp_w + 3; k++) begin
      @(negedge clk);
      if (want_post ? post : pre) begin
        if (k <= exp_w) len++; else extra++;
      end
      if (want_post ? pre : post) other++;
      if (done != (k == exp_w + 1)) derr++;
    end
    check(len == exp_w && extra == 0, tag, len + extra, exp_w);
    check(other == 0, $sformatf("R9 %s wrong output cycles", tag), other, 0);
    check(derr == 0, $sformatf("R8 %s done timing errors", tag), derr, 0);
  endtask

  task automatic fire(input bit post_kind, input int exp_w, input string tag);
    ack = 1'b1; req = ~post_kind; rrq = post_kind;
    measure(post_kind, exp_w, tag);
    ack = 1'b0; req = 1'b0; rrq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    check(!pre && !post && !done, "R1 outputs in reset", {pre, post, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pre && !post && !done, "R1 outputs after reset", {pre, post, done}, 0);
    fire(1'b0, 4, "R1 default width");

    // one line alone or no ack: nothing
    hi = 0;
    req = 1'b1; rrq = 1'b1;
    repeat (4) begin @(negedge clk); hi += int'(pre) + int'(post); end
    check(hi == 0, "R2 no pulse without ack", hi, 0);
    // ack arrives last, both rise together
    ack = 1'b1;
    measure(1'b1, 4, "R7 simultaneous triggers");
    ack = 1'b0; req = 1'b0; rrq = 1'b0;
    @(negedge clk);

    // req last with ack held
    ack = 1'b1;
    @(negedge clk);
    req = 1'b1;
    measure(1'b0, 4, "R2 ack first then req");
    req = 1'b0; ack = 1'b0;
    @(negedge clk);

    for (int w = 0; w <= 13; w++) begin
      int wv = (w == 13) ? 255 : w;
      int ew = (wv == 0) ? 1 : wv;
      write_width(wv);
      fire(1'b0, ew, $sformatf("R2 R4 R5 pre length w=%0d", wv));
      fire(1'b1, ew, $sformatf("R3 R4 R5 post length w=%0d", wv));
    end

    // width write during a pulse
    write_width(8);
    begin
      int len = 0;
      ack = 1'b1; req = 1'b1;
      for (int k = 1; k <= 11; k++) begin
        @(negedge clk);
        if (pre) len++;
        if (k == 2) begin we = 1'b1; wd = 8'd3; end
        if (k == 3) we = 1'b0;
      end
      check(len == 8, "R5 mid-pulse write keeps length", len, 8);
      ack = 1'b0; req = 1'b0;
      @(negedge clk);
    end
    fire(1'b0, 3, "R5 new width after write");

    // retrigger during pulse, then held levels
    write_width(6);
    begin
      int len = 0, pst = 0, late = 0, dpos = 0;
      ack = 1'b1; req = 1'b1;
      for (int k = 1; k <= 12; k++) begin
        @(negedge clk);
        if (pre && k <= 6) len++;
        if (pre && k > 6) late++;
        if (post) pst++;
        if (done) dpos = k;
        if (k == 2) req = 1'b0;
        if (k == 3) begin req = 1'b1; rrq = 1'b1; end
      end
      check(len == 6 && late == 0, "R6 pulse unaffected by retrigger", len + late, 6);
      check(pst == 0, "R6 retrigger during pulse ignored", pst, 0);
      check(dpos == 7, "R8 done after retrigger pulse", dpos, 7);
      ack = 1'b0; req = 1'b0; rrq = 1'b0;
      @(negedge clk);
    end
    fire(1'b1, 6, "R6 retrigger after release");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule